// File: doc/BRIEF.md
# Receive Buffer Credit Tracker with Hysteresis Backpressure

This block keeps a count of free receive buffers for each flow-control context of a multi-channel DMA engine and raises a backpressure signal toward the receive source when buffers run short. Channels are grouped in pairs, and each pair shares one context. The context index is the channel number shifted right by one. The even channel of each pair is the receive channel. Software adds credit by writing a count of freshly freed buffers to the context's allocation register. The DMA engine pulses a consume strobe with a channel number each time it fills a buffer.

Each context holds a low and a high threshold. Backpressure turns on when the credit falls below the low threshold. It turns off only once the credit has climbed back to the high threshold or above, so the signal does not chatter around a single level. Software can also put a context into a forced mode, which masks its backpressure. A global configuration word enables the engine and each context's flow control, and reports the channel count. A separate register drives one reset line per channel. All registers are reached through a plain word-addressed read/write port that has combinational read data.

Top module: `rxfc_tracker`

## Requirements
- R1: After reset, every credit count, threshold, force flag, configuration bit and channel reset line is 0. `rx_pause` and `dma_en` are 0.
- R2: The allocation register of context k is at word index 3+3k. Writing it with bit 31 clear adds bits [CNT_W-1:0] of the data to that context's credit. The credit saturates at 2^CNT_W-1.
- R3: A consume strobe on an even channel c subtracts one credit from context c>>1, and the credit stops at 0. A strobe on an odd channel changes no credit.
- R4: The low threshold of context k is at word 1+3k and the high threshold at word 2+3k. A context's backpressure state sets when its credit is below the low threshold. It clears when the credit is at or above the high threshold. Otherwise it keeps its value.
- R5: An allocation write with bit 31 set puts the context in forced mode and adds no credit. An allocation write with bit 31 clear leaves forced mode. While forced, the context's `rx_pause` bit is 0. Reading the allocation register returns the force flag in bit 31 and the credit in bits [CNT_W-1:0].
- R6: The configuration register is at word 0. Bit 0 is the global enable, which drives `dma_en`. Bit k+1 enables flow control for context k. `rx_pause[k]` is 1 only when the global enable, context k's enable and its backpressure state are all set and the context is not forced.
- R7: A read of word 0 returns the global enable in bit 0, the context enables in bits k+1 and NUM_CH in bits 27:24. All other bits read as 0.
- R8: The channel reset register is at word 13. Bit c drives `chan_rst[c]` and reads back. Writing this register changes no credit.
- R9: An allocation write and a consume on the same context in the same cycle leave the credit at old + N - 1, with saturation at both ends.
- R10: Threshold registers read back the value written, in bits [CNT_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rx_take | input | 1 | DMA engine consumed one buffer |
| rx_take_ch | input | $clog2(NUM_CH) | Channel of the consumed buffer |
| dma_en | output | 1 | Global enable bit |
| chan_rst | output | NUM_CH | Per-channel reset lines |
| rx_pause | output | NUM_CH/2 | Backpressure per context |

## Verification
The bench works on the edges of the hysteresis band. A credit that equals the low threshold must not raise backpressure, and a credit one below it must. Once raised, backpressure must hold through credits between the two thresholds; a design using a single comparator would release it early. Credit is driven past both saturation limits. An adder without a clamp wraps to a small value, and a decrement without a floor wraps to full. A consume on an odd channel must change nothing, which catches a decoder that ignores the channel LSB. A same-cycle allocate and consume must give old+N-1, which catches a priority mux that drops one of them. Forced mode and the enable bits must each mask `rx_pause` on their own. The bench also checks that writing the channel reset register leaves the credits unchanged.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  localparam int CFG_WORD     = 0;
  localparam int CTX_BASE     = 1;
  localparam int CTX_STRIDE   = 3;
  localparam int CHRST_WORD   = 13;
  localparam int FORCE_BIT    = 31;
  localparam int NCH_LSB      = 24;
  localparam int NCH_BITS     = 4;

  typedef enum logic [1:0] {
    SLOT_LO    = 2'd0,
    SLOT_HI    = 2'd1,
    SLOT_ALLOC = 2'd2
  } ctx_slot_e;

  function automatic int ctx_word(input int ctx, input ctx_slot_e slot);
    return CTX_BASE + CTX_STRIDE * ctx + int'(slot);
  endfunction
endpackage

// File: rtl/rxfc_decode.sv
module rxfc_decode #(
  parameter int NCTX   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic              cfg_we,
  output logic              chrst_we,
  output logic [NCTX-1:0]   lo_we,
  output logic [NCTX-1:0]   hi_we,
  output logic [NCTX-1:0]   alloc_we
);
  import rxfc_pkg::*;

  assign cfg_we   = reg_we && (reg_addr == ADDR_W'(CFG_WORD));
  assign chrst_we = reg_we && (reg_addr == ADDR_W'(CHRST_WORD));

  for (genvar k = 0; k < NCTX; k++) begin : g_dec
    assign lo_we[k]    = reg_we && (reg_addr == ADDR_W'(ctx_word(k, SLOT_LO)));
    assign hi_we[k]    = reg_we && (reg_addr == ADDR_W'(ctx_word(k, SLOT_HI)));
    assign alloc_we[k] = reg_we && (reg_addr == ADDR_W'(ctx_word(k, SLOT_ALLOC)));
  end
endmodule

// File: rtl/rxfc_credit_ctx.sv
module rxfc_credit_ctx #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic             alloc_we,
  input  logic [31:0]      wdata,
  input  logic             dec,
  input  logic             gate_en,
  output logic [CNT_W-1:0] lo_q,
  output logic [CNT_W-1:0] hi_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             force_q,
  output logic             hyst_q,
  output logic             pause
);
  import rxfc_pkg::*;

  logic [CNT_W-1:0] add_amt;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             hyst_d;

  // next-state logic
  always_comb begin
    add_amt = (alloc_we && !wdata[FORCE_BIT]) ? wdata[CNT_W-1:0] : '0;
    sum     = {1'b0, cnt_q} + {1'b0, add_amt};
    if (dec && (sum != '0)) sum = sum - 1'b1;
    cnt_d   = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    cnt_en  = alloc_we || dec;
    if (cnt_d < lo_q)       hyst_d = 1'b1;
    else if (cnt_d >= hi_q) hyst_d = 1'b0;
    else                    hyst_d = hyst_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      cnt_q   <= '0;
      force_q <= 1'b0;
      hyst_q  <= 1'b0;
    end else begin
      if (lo_we)    lo_q    <= wdata[CNT_W-1:0];
      if (hi_we)    hi_q    <= wdata[CNT_W-1:0];
      if (cnt_en)   cnt_q   <= cnt_d;
      if (alloc_we) force_q <= wdata[FORCE_BIT];
      hyst_q <= hyst_d;
    end
  end

  assign pause = gate_en && !force_q && hyst_q;
endmodule

// File: rtl/rxfc_tracker.sv
module rxfc_tracker #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic                       rx_take,
  input  logic [$clog2(NUM_CH)-1:0]  rx_take_ch,
  output logic                       dma_en,
  output logic [NUM_CH-1:0]          chan_rst,
  output logic [NUM_CH/2-1:0]        rx_pause
);
  import rxfc_pkg::*;

  localparam int NCTX = NUM_CH / 2;
  localparam int CH_W = $clog2(NUM_CH);

  logic              cfg_we, chrst_we;
  logic [NCTX-1:0]   lo_we, hi_we, alloc_we;
  logic              gen_q, gen_d;
  logic [NCTX-1:0]   fce_q, fce_d;
  logic [NUM_CH-1:0] chrst_q, chrst_d;
  logic [NCTX-1:0]   dec_vec, add_vec, force_vec, hyst_vec;
  logic [NCTX*CNT_W-1:0] cnt_flat, lo_flat, hi_flat;

  rxfc_decode #(.NCTX(NCTX), .ADDR_W(ADDR_W)) u_dec (
    .reg_we(reg_we), .reg_addr(reg_addr), .cfg_we(cfg_we),
    .chrst_we(chrst_we), .lo_we(lo_we), .hi_we(hi_we), .alloc_we(alloc_we)
  );

  // global next state
  always_comb begin
    gen_d   = reg_wdata[0];
    fce_d   = reg_wdata[NCTX:1];
    chrst_d = reg_wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      fce_q   <= '0;
      chrst_q <= '0;
    end else begin
      if (cfg_we) begin
        gen_q <= gen_d;
        fce_q <= fce_d;
      end
      if (chrst_we) chrst_q <= chrst_d;
    end
  end

  for (genvar k = 0; k < NCTX; k++) begin : g_ctx
    assign dec_vec[k] = rx_take && !rx_take_ch[0] &&
                        (rx_take_ch[CH_W-1:1] == (CH_W-1)'(k));
    assign add_vec[k] = alloc_we[k] && !reg_wdata[FORCE_BIT];

    rxfc_credit_ctx #(.CNT_W(CNT_W)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .lo_we(lo_we[k]), .hi_we(hi_we[k]), .alloc_we(alloc_we[k]),
      .wdata(reg_wdata), .dec(dec_vec[k]), .gate_en(gen_q && fce_q[k]),
      .lo_q(lo_flat[k*CNT_W +: CNT_W]), .hi_q(hi_flat[k*CNT_W +: CNT_W]),
      .cnt_q(cnt_flat[k*CNT_W +: CNT_W]), .force_q(force_vec[k]),
      .hyst_q(hyst_vec[k]), .pause(rx_pause[k])
    );
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CFG_WORD)) begin
      reg_rdata[0]      = gen_q;
      reg_rdata[NCTX:1] = fce_q;
      reg_rdata[NCH_LSB +: NCH_BITS] = NCH_BITS'(NUM_CH);
    end
    if (reg_addr == ADDR_W'(CHRST_WORD)) reg_rdata[NUM_CH-1:0] = chrst_q;
    for (int k = 0; k < NCTX; k++) begin
      if (reg_addr == ADDR_W'(ctx_word(k, SLOT_LO)))
        reg_rdata[CNT_W-1:0] = lo_flat[k*CNT_W +: CNT_W];
      if (reg_addr == ADDR_W'(ctx_word(k, SLOT_HI)))
        reg_rdata[CNT_W-1:0] = hi_flat[k*CNT_W +: CNT_W];
      if (reg_addr == ADDR_W'(ctx_word(k, SLOT_ALLOC))) begin
        reg_rdata[CNT_W-1:0] = cnt_flat[k*CNT_W +: CNT_W];
        reg_rdata[FORCE_BIT] = force_vec[k];
      end
    end
  end

  assign dma_en   = gen_q;
  assign chan_rst = chrst_q;
endmodule

// File: rtl/rxfc_tracker_chk.sv
module rxfc_tracker_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_we,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic                       dma_en,
  input logic [NUM_CH-1:0]          chan_rst,
  input logic [NUM_CH/2-1:0]        rx_pause,
  input logic [NUM_CH/2-1:0]        dec_vec,
  input logic [NUM_CH/2-1:0]        add_vec,
  input logic [NUM_CH/2-1:0]        force_vec,
  input logic [NUM_CH/2-1:0]        hyst_vec,
  input logic [NUM_CH/2*CNT_W-1:0]  cnt_flat,
  input logic [NUM_CH/2*CNT_W-1:0]  lo_flat,
  input logic [NUM_CH/2*CNT_W-1:0]  hi_flat
);
  localparam int NCTX = NUM_CH / 2;

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> (rx_pause == '0)); // R6

  AST_CHRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == ADDR_W'(13)) |=> $stable(chan_rst)); // R8

  for (genvar k = 0; k < NCTX; k++) begin : g_chk
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vec[k] && !add_vec[k] && cnt_flat[k*CNT_W +: CNT_W] != '0) |=>
      (cnt_flat[k*CNT_W +: CNT_W] == $past(cnt_flat[k*CNT_W +: CNT_W]) - CNT_W'(1))); // R3

    AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vec[k] && !add_vec[k] && cnt_flat[k*CNT_W +: CNT_W] == '0) |=>
      (cnt_flat[k*CNT_W +: CNT_W] == '0)); // R3

    AST_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (add_vec[k] && !dec_vec[k]) |=>
      (cnt_flat[k*CNT_W +: CNT_W] >= $past(cnt_flat[k*CNT_W +: CNT_W]))); // R2

    AST_PAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hyst_vec[k]) |->
      (cnt_flat[k*CNT_W +: CNT_W] < $past(lo_flat[k*CNT_W +: CNT_W]))); // R4

    AST_PAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hyst_vec[k]) |->
      (cnt_flat[k*CNT_W +: CNT_W] >= $past(hi_flat[k*CNT_W +: CNT_W]))); // R4

    AST_FORCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      force_vec[k] |-> !rx_pause[k]); // R5
  end
endmodule

bind rxfc_tracker rxfc_tracker_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .dma_en(dma_en), .chan_rst(chan_rst), .rx_pause(rx_pause),
  .dec_vec(dec_vec), .add_vec(add_vec), .force_vec(force_vec),
  .hyst_vec(hyst_vec), .cnt_flat(cnt_flat), .lo_flat(lo_flat), .hi_flat(hi_flat)
);

// File: tb/sim_rxfc_tracker.sv
`timescale 1ns/1ps
module sim_rxfc_tracker;
  localparam int NUM_CH = 8;
  localparam int NCTX   = 4;
  localparam int CNT_W  = 8;
  localparam int MAXC   = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_take = 1'b0;
  logic [2:0]  rx_take_ch = '0;
  logic        dma_en;
  logic [7:0]  chan_rst;
  logic [3:0]  rx_pause;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_cnt[NCTX], m_lo[NCTX], m_hi[NCTX];
  bit m_force[NCTX], m_st[NCTX], m_fce[NCTX];
  bit m_gen;
  int m_rst;

  always #10 clk = ~clk;

  rxfc_tracker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_take(rx_take),
    .rx_take_ch(rx_take_ch), .dma_en(dma_en), .chan_rst(chan_rst),
    .rx_pause(rx_pause)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCTX; k++) begin
        m_cnt[k] = 0; m_lo[k] = 0; m_hi[k] = 0;
        m_force[k] = 0; m_st[k] = 0; m_fce[k] = 0;
      end
      m_gen = 0; m_rst = 0;
    end else begin
      for (int k = 0; k < NCTX; k++) begin
        int t;
        t = m_cnt[k];
        if (reg_we && reg_addr == 3 + 3*k && !reg_wdata[31]) t += int'(reg_wdata[7:0]);
        if (rx_take && rx_take_ch[0] == 1'b0 && int'(rx_take_ch >> 1) == k && t > 0) t -= 1;
        if (t > MAXC) t = MAXC;
        m_cnt[k] = t;
        if (t < m_lo[k]) m_st[k] = 1;
        else if (t >= m_hi[k]) m_st[k] = 0;
      end
      if (reg_we) begin
        if (reg_addr == 0) begin
          m_gen = reg_wdata[0];
          for (int k = 0; k < NCTX; k++) m_fce[k] = reg_wdata[k+1];
        end
        if (reg_addr == 13) m_rst = int'(reg_wdata[7:0]);
        for (int k = 0; k < NCTX; k++) begin
          if (reg_addr == 1 + 3*k) m_lo[k] = int'(reg_wdata[7:0]);
          if (reg_addr == 2 + 3*k) m_hi[k] = int'(reg_wdata[7:0]);
          if (reg_addr == 3 + 3*k) m_force[k] = reg_wdata[31];
        end
      end
    end
  end

  function automatic logic [3:0] m_pause();
    logic [3:0] p;
    for (int k = 0; k < NCTX; k++) p[k] = m_gen && m_fce[k] && !m_force[k] && m_st[k];
    return p;
  endfunction

  // compare on every clock (R4, R6, R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (rx_pause !== m_pause() || dma_en !== m_gen || chan_rst !== m_rst[7:0]) begin
        n_fail++;
        $display("FAIL R4/R6/R8 cycle compare: pause=%h dma_en=%b rst=%h exp pause=%h dma_en=%b rst=%h",
                 rx_pause, dma_en, chan_rst, m_pause(), m_gen, m_rst[7:0]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic take(input int ch);
    @(negedge clk); rx_take = 1; rx_take_ch = 3'(ch);
    @(negedge clk); rx_take = 0;
  endtask

  task automatic rd(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk); reg_addr = 4'(a); #2;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 pause at reset", {28'd0, rx_pause}, 32'd0);
    chk("R1 dma_en at reset", {31'd0, dma_en}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1/R7 cfg after reset", 0, 32'h0800_0000);
    rd("R1 credit ctx0 after reset", 3, 32'd0);
    rd("R1 chan reset reg", 13, 32'd0);

    wr(0, 32'h1F);
    rd("R7 cfg readback", 0, 32'h0800_001F);

    wr(1, 32'd2);
    wr(2, 32'd5);
    idle(2);
    chk("R4 pause set below low", {31'd0, rx_pause[0]}, 32'd1);
    rd("R10 low readback", 1, 32'd2);
    rd("R10 high readback", 2, 32'd5);

    wr(3, 32'd3); idle(1);
    chk("R4 pause held inside band", {31'd0, rx_pause[0]}, 32'd1);
    rd("R2 credit after add 3", 3, 32'd3);
    wr(3, 32'd2); idle(1);
    chk("R4 pause cleared at high", {31'd0, rx_pause[0]}, 32'd0);

    take(0); take(0); take(0); idle(1);
    chk("R4 no pause at credit equal low", {31'd0, rx_pause[0]}, 32'd0);
    rd("R3 credit after 3 consumes", 3, 32'd2);
    take(0); idle(1);
    chk("R4 pause at credit low-1", {31'd0, rx_pause[0]}, 32'd1);

    take(1); idle(1);
    rd("R3 odd channel ignored", 3, 32'd1);
    take(0); take(0); idle(1);
    rd("R3 credit floors at zero", 3, 32'd0);

    wr(6, 32'd200); wr(6, 32'd100);
    rd("R2 credit saturates at max", 6, 32'd255);

    wr(9, 32'd10);
    @(negedge clk); reg_we = 1; reg_addr = 4'd9; reg_wdata = 32'd4; rx_take = 1; rx_take_ch = 3'd4;
    @(negedge clk); reg_we = 0; rx_take = 0;
    rd("R9 add and consume same cycle", 9, 32'd13);

    wr(3, 32'h8000_0000); idle(1);
    chk("R5 force masks pause", {31'd0, rx_pause[0]}, 32'd0);
    rd("R5 force readback", 3, 32'h8000_0000);
    wr(3, 32'd0); idle(1);
    chk("R5 force cleared pause back", {31'd0, rx_pause[0]}, 32'd1);

    wr(0, 32'h1D); idle(1);
    chk("R6 context enable masks pause", {31'd0, rx_pause[0]}, 32'd0);
    wr(0, 32'h1F); idle(1);
    chk("R6 context reenabled", {31'd0, rx_pause[0]}, 32'd1);
    wr(0, 32'h1E); idle(1);
    chk("R6 global enable masks all", {28'd0, rx_pause}, 32'd0);
    chk("R6 dma_en off", {31'd0, dma_en}, 32'd0);

    wr(13, 32'h05); idle(1);
    chk("R8 chan_rst driven", {24'd0, chan_rst}, 32'h05);
    rd("R8 chan reset readback", 13, 32'h05);
    rd("R8 credits untouched", 9, 32'd13);
    wr(13, 32'h00); idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule